// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block collects message-signalled interrupts for a PCIe root port and turns them into a single level interrupt for the CPU. Software sets a 64-bit capture address. Any inbound memory write that lands exactly on that address is treated as an interrupt message. The write data is read as a vector index from 0 to 31. When the matching bit of the enable register is set, the block latches the matching status bit. A mask register decides which pending vectors are allowed to raise the CPU line.

Software reaches the block through a 32-bit register port. Writes on that port take effect at the next clock edge, and reads return data in the same cycle. Interrupt messages come in on a separate port, which carries an address, a data word, a byte count and a valid strobe. A two-state machine drives the CPU line:

- `IRQ_QUIET` moves to `IRQ_RAISED` on the transition `T_CAPTURE_PENDING`. This happens when an accepted capture leaves an unmasked status bit set.
- `IRQ_RAISED` moves back to `IRQ_QUIET` on the transition `T_STATUS_DRAINED`. This happens when a software write to status leaves the whole status register at zero.

The line does not change in any other case.

Top module: `msi_cap_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The capture address low word is at offset 0x820 and the high word is at offset 0x824. A write to one word leaves the other word unchanged, and both words read back their stored values.
- R3: The 32-bit vector enable register is at 0x828 and the 32-bit vector mask register is at 0x82C. Both read back what was written.
- R4: An inbound write is accepted when all of these hold: `in_valid` is high, `in_bytes` is 4, `in_addr` equals {high word, low word}, the enable register is nonzero, and `in_data` is a value N below 32. If enable bit N is 1, status (offset 0x830) gains bit N at the next clock edge.
- R5: An accepted inbound write whose enable bit N is 0 leaves status unchanged.
- R6: Status is unchanged by an inbound write in any of these cases: the address differs from the capture address, `in_bytes` is not 4, `in_data` is 32 or more, or the enable register is zero.
- R7: On the edge that takes an accepted inbound write, `irq_o` rises if the updated status AND NOT mask is nonzero. If every pending bit is masked, `irq_o` stays low.
- R8: A software write to status XORs the written value into status, so writing a 1 flips that bit.
- R9: `irq_o` falls only on a status write that leaves status at zero. A partial clear or a mask change leaves `irq_o` high.
- R10: A read of an unmapped offset returns zero, and a write to an unmapped offset changes no register.
- R11: When a status write and an accepted inbound write arrive in the same cycle, status becomes (old XOR written) OR the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| in_valid | input | 1 | Inbound write strobe |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector index) |
| in_bytes | input | 3 | Inbound access size in bytes |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The hardest case to reach from the ports is a status write and an accepted capture landing on the same clock edge while the line is raised. Only that case shows whether the XOR and the capture OR combine in the right order, and whether the drain transition is correctly held off. The bench drives the register port and the inbound port in the same cycle, using one shared task. It first brings the line up with a real capture, so the combined edge starts from `IRQ_RAISED`. A second hard case is a set of masked or partial clears that must leave the line high. The bench builds this by capturing two vectors, masking everything, and then clearing status one bit at a time.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
    localparam int OFS_W  = 12;
    localparam int DATA_W = 32;

    localparam logic [OFS_W-1:0] OFS_CAP_LO = 12'h820;
    localparam logic [OFS_W-1:0] OFS_CAP_HI = 12'h824;
    localparam logic [OFS_W-1:0] OFS_ENABLE = 12'h828;
    localparam logic [OFS_W-1:0] OFS_MASK   = 12'h82C;
    localparam logic [OFS_W-1:0] OFS_STATUS = 12'h830;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [OFS_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_VEC-1:0]  set_vec,
    output logic [2*DATA_W-1:0] cap_addr,
    output logic [NUM_VEC-1:0]  enable_q,
    output logic [NUM_VEC-1:0]  mask_q,
    output logic [NUM_VEC-1:0]  status_q,
    output logic [NUM_VEC-1:0]  status_d,
    output logic                sts_wr
);
    logic [DATA_W-1:0] lo_q, hi_q;

    assign sts_wr   = reg_wr && (reg_addr == OFS_STATUS);
    assign cap_addr = {hi_q, lo_q};

    always_comb begin
        status_d = status_q;
        if (sts_wr) begin
            status_d = status_q ^ reg_wdata[NUM_VEC-1:0];
        end
        status_d = status_d | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_q     <= '0;
            enable_q <= '0;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            status_q <= status_d;
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CAP_LO: lo_q     <= reg_wdata;
                    OFS_CAP_HI: hi_q     <= reg_wdata;
                    OFS_ENABLE: enable_q <= reg_wdata[NUM_VEC-1:0];
                    OFS_MASK:   mask_q   <= reg_wdata[NUM_VEC-1:0];
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CAP_LO: reg_rdata = lo_q;
            OFS_CAP_HI: reg_rdata = hi_q;
            OFS_ENABLE: reg_rdata[NUM_VEC-1:0] = enable_q;
            OFS_MASK:   reg_rdata[NUM_VEC-1:0] = mask_q;
            OFS_STATUS: reg_rdata[NUM_VEC-1:0] = status_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC   = 32,
    parameter int WORD_SIZE = 4
) (
    input  logic                in_valid,
    input  logic [2*DATA_W-1:0] in_addr,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [2:0]          in_bytes,
    input  logic [2*DATA_W-1:0] cap_addr,
    input  logic [NUM_VEC-1:0]  enable_q,
    output logic                hit,
    output logic [NUM_VEC-1:0]  set_vec
);
    logic window_open;

    assign window_open = |enable_q;
    assign hit = in_valid && (in_bytes == 3'(WORD_SIZE)) && window_open &&
                 (in_addr == cap_addr) && (in_data < DATA_W'(NUM_VEC));

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign set_vec[v] = hit && enable_q[v] && (in_data == DATA_W'(v));
    end
endmodule

// File: rtl/msi_cap_irq_fsm.sv
module msi_cap_irq_fsm
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic               sts_wr,
    input  logic [NUM_VEC-1:0] status_d,
    input  logic [NUM_VEC-1:0] mask_q,
    output logic               irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (hit && ((status_d & ~mask_q) != '0)) begin
                    state_d = IRQ_RAISED;
                end
            end
            IRQ_RAISED: begin
                if (sts_wr && (status_d == '0)) begin
                    state_d = IRQ_QUIET;
                end
            end
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [OFS_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                in_valid,
    input  logic [2*DATA_W-1:0] in_addr,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [2:0]          in_bytes,
    output logic                irq_o
);
    logic [2*DATA_W-1:0] cap_addr;
    logic [NUM_VEC-1:0]  enable_q, mask_q, status_q, status_d, set_vec;
    logic                sts_wr, cap_hit;

    msi_cap_regs #(.NUM_VEC(NUM_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_vec(set_vec),
        .cap_addr(cap_addr), .enable_q(enable_q), .mask_q(mask_q),
        .status_q(status_q), .status_d(status_d), .sts_wr(sts_wr)
    );

    msi_cap_decode #(.NUM_VEC(NUM_VEC)) u_decode (
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .in_bytes(in_bytes), .cap_addr(cap_addr), .enable_q(enable_q),
        .hit(cap_hit), .set_vec(set_vec)
    );

    msi_cap_irq_fsm #(.NUM_VEC(NUM_VEC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(cap_hit), .sts_wr(sts_wr),
        .status_d(status_d), .mask_q(mask_q), .irq(irq_o)
    );
endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker #(
    parameter int NUM_VEC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic               hit,
    input logic               sts_wr,
    input logic [NUM_VEC-1:0] set_vec,
    input logic [NUM_VEC-1:0] status_q,
    input logic [NUM_VEC-1:0] enable_q
);
    AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0));                                            // R9
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));                                           // R7
    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(sts_wr) && (status_q == '0)));                  // R9
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !sts_wr) |=> $stable(status_q));                             // R6
    AST_SET_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !sts_wr) |=> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0)); // R5
    AST_ONE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));                                                   // R4
endmodule

bind msi_cap_ctrl msi_cap_checker #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_o), .hit(cap_hit), .sts_wr(sts_wr),
    .set_vec(set_vec), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/test_msi_cap_ctrl.sv
module test_msi_cap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [2:0]  in_bytes = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] CAP = 64'h0000_0001_F000_0080;

    always #5 clk = ~clk;

    msi_cap_ctrl i_msi_cap_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .in_data(in_data), .in_bytes(in_bytes), .irq_o(irq_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(bit w, logic [11:0] a, logic [31:0] d,
                         bit iv, logic [63:0] ia, logic [31:0] id, logic [2:0] ib);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        in_valid = iv; in_addr = ia; in_data = id; in_bytes = ib;
        @(negedge clk);
        reg_wr = 1'b0; in_valid = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, '0, '0, '0);
    endtask

    task automatic msg(logic [63:0] ia, logic [31:0] id, logic [2:0] ib);
        cycle(1'b0, '0, '0, 1'b1, ia, id, ib);
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic expect_reg(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 lo", 12'h820, 32'h0);
        expect_reg("R1 hi", 12'h824, 32'h0);
        expect_reg("R1 enable", 12'h828, 32'h0);
        expect_reg("R1 mask", 12'h82C, 32'h0);
        expect_reg("R1 status", 12'h830, 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_regs();
        wr(12'h820, 32'hF000_0040);
        wr(12'h824, 32'h0000_0001);
        wr(12'h820, 32'hF000_0080);
        expect_reg("R2 lo rewrite", 12'h820, 32'hF000_0080);
        expect_reg("R2 hi kept", 12'h824, 32'h0000_0001);
        wr(12'h828, 32'h0000_00FF);
        wr(12'h82C, 32'h0000_0002);
        expect_reg("R3 enable", 12'h828, 32'h0000_00FF);
        expect_reg("R3 mask", 12'h82C, 32'h0000_0002);
    endtask

    task automatic t_capture();
        msg(CAP, 32'd3, 3'd4);
        expect_reg("R4 status bit3", 12'h830, 32'h8);
        chk("R7 irq rises", 32'(irq_o), 32'h1);
        msg(CAP, 32'd20, 3'd4);
        expect_reg("R5 disabled vector", 12'h830, 32'h8);
    endtask

    task automatic t_ignored();
        msg(CAP ^ 64'h4, 32'd0, 3'd4);
        expect_reg("R6 addr mismatch", 12'h830, 32'h8);
        msg(CAP, 32'd0, 3'd2);
        expect_reg("R6 size", 12'h830, 32'h8);
        msg(CAP, 32'd40, 3'd4);
        expect_reg("R6 data range", 12'h830, 32'h8);
    endtask

    task automatic t_clear_and_mask();
        wr(12'h830, 32'h8);
        expect_reg("R8 xor clear", 12'h830, 32'h0);
        chk("R9 irq falls", 32'(irq_o), 32'h0);
        msg(CAP, 32'd1, 3'd4);
        expect_reg("R4 bit1", 12'h830, 32'h2);
        chk("R7 masked stays low", 32'(irq_o), 32'h0);
        msg(CAP, 32'd0, 3'd4);
        chk("R7 unmasked rises", 32'(irq_o), 32'h1);
        wr(12'h82C, 32'hFFFF_FFFF);
        chk("R9 mask keeps irq", 32'(irq_o), 32'h1);
        wr(12'h830, 32'h1);
        expect_reg("R8 partial", 12'h830, 32'h2);
        chk("R9 partial keeps irq", 32'(irq_o), 32'h1);
        wr(12'h830, 32'h6);
        expect_reg("R8 xor sets", 12'h830, 32'h4);
        wr(12'h830, 32'h4);
        chk("R9 drained", 32'(irq_o), 32'h0);
        wr(12'h82C, 32'h0);
    endtask

    task automatic t_enable_zero();
        wr(12'h828, 32'h0);
        msg(CAP, 32'd0, 3'd4);
        expect_reg("R6 window closed", 12'h830, 32'h0);
        chk("R6 irq low", 32'(irq_o), 32'h0);
        wr(12'h828, 32'h0000_00FF);
    endtask

    task automatic t_unmapped();
        wr(12'h834, 32'hA5A5_A5A5);
        expect_reg("R10 read 834", 12'h834, 32'h0);
        expect_reg("R10 read 700", 12'h700, 32'h0);
        expect_reg("R10 enable kept", 12'h828, 32'h0000_00FF);
        expect_reg("R10 lo kept", 12'h820, 32'hF000_0080);
    endtask

    task automatic t_same_cycle();
        msg(CAP, 32'd2, 3'd4);
        chk("R7 raised", 32'(irq_o), 32'h1);
        cycle(1'b1, 12'h830, 32'h4, 1'b1, CAP, 32'd5, 3'd4);
        expect_reg("R11 xor then or", 12'h830, 32'h20);
        chk("R11 irq held", 32'(irq_o), 32'h1);
        wr(12'h830, 32'h20);
        chk("R9 final drain", 32'(irq_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_regs();
        t_capture();
        t_ignored();
        t_clear_and_mask();
        t_enable_zero();
        t_unmapped();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule